// File: doc/BRIEF.md
# Pin-Fault RAM Test Sequencer

This block exercises a small coincident-select static RAM whose cells are picked by one line from an upper group of four select lines and one line from a lower group of four. It drives the eight select lines and the two write strobes, one for storing a 1 and one for storing a 0. It reads back the two active-low sense outputs and decides whether the memory and its pins are sound. A single start pulse runs the whole programme. The programme has two short tests, one per sense pin, and then seven cell-isolation tests over a fixed group of seven cells. In that group every select line appears both high and low, so an open or stuck line shows up as a miscompare.

The programme is a list of vectors. Each vector holds its select and strobe values for a fixed number of clock cycles. The sense outputs are compared only once per vector, at a late strobe cycle, after the memory outputs have settled. The run stops at the first miscompare. The block then reports which test unit and which vector failed and what the two sense pins showed. Those results stay valid until the next start.

Top module: `ram_pin_test_seq`

## Requirements
- R1: The seven test cells, numbered 1 to 7, have select patterns 8'h18, 8'h14, 8'h12, 8'h11, 8'h28, 8'h48 and 8'h88 (bit 7 is the top select line). Over these read addresses every select line is seen both high and low. Any driven select pattern has either zero or exactly two lines high.
- R2: In a cell-isolation unit with target cell T, the vectors run as follows. Vectors 0–6 store 1 into cells 1..7 in order. Vector 7 stores 0 into T. Vector 8 is the all-low deselect. Vectors 9–14 read the six other cells in ascending order, expecting a 1. Vector 15 reads T, expecting a 0.
- R3: Units are numbered 0 to 8 and run in that order. Units 2 to 8 are cell-isolation units whose targets are cells 1 to 7 in turn.
- R4: Units 0 and 1 are minimum-pin units and use cell 1 only. Their six vectors are: store 1, deselect, read, store 0, deselect, read.
- R5: Sense polarity: sense_zero_n is high when the selected cell holds 1 and low when it holds 0, and sense_one_n is the inverse. Unit 0 compares only sense_zero_n. Unit 1 compares only sense_one_n. Cell-isolation reads compare both pins.
- R6: A read vector and the deselect vector keep both write strobes low. The deselect vector also keeps all select lines low. The two strobes are never high together.
- R7: Each vector is held for PERIOD clock cycles, with select and strobes stable. The sense pins are compared only in the cycle where the vector's cycle count equals STROBE_AT. Sense values at all other cycles have no effect.
- R8: The run stops at the first miscompare. On that clock edge done pulses with pass low. fail_unit_o then holds the unit number, fail_vec_o the vector index within the unit, and fail_sense_o the observed {sense_one_n, sense_zero_n}.
- R9: A start pulse while idle begins a run of 124 vectors. busy stays high for the whole run. A fault-free run raises done for one cycle, PERIOD*124 cycles after start is taken, with pass high. A start while busy is ignored. While idle the select lines and strobes are low, and the result outputs hold until the next accepted start.
- R10: After reset, busy, done and pass are low, and the select lines, strobes and failure fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a full test run |
| sel_o | output | 8 | One-hot-per-group select lines to the RAM |
| wr_one_o | output | 1 | Strobe that stores a 1 into the selected cell |
| wr_zero_o | output | 1 | Strobe that stores a 0 into the selected cell |
| sense_one_n_i | input | 1 | Active-low sense, low when the cell holds 1 |
| sense_zero_n_i | input | 1 | Active-low sense, low when the cell holds 0 |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| pass_o | output | 1 | High after a run with no miscompare |
| fail_unit_o | output | 4 | Unit number of the first miscompare |
| fail_vec_o | output | 4 | Vector index within the failing unit |
| fail_sense_o | output | 2 | Observed {sense_one_n, sense_zero_n} at the failure |

## Verification
The assertions assume that start_i is a clean synchronous level. They also assume the sense inputs settle before the strobe cycle of each vector, because a glitch inside a vector can only matter at that cycle. The bench RAM model derives the sense pins combinationally from the driven select lines, the stored bits and an injected fault. It can also corrupt them in every cycle except the strobe cycle, so the late compare point is tested directly. Faults are drawn with a fixed seed: stuck sense pins, dead strobes, stuck-high or stuck-low select lines, and cells that cannot be cleared. The expected failing unit, vector, sense pair and run length for each fault come from bench functions.

// File: rtl/ram_pst_pkg.sv
package ram_pst_pkg;

    localparam int SEL_W   = 8;
    localparam int NCELL   = 7;
    localparam int NUNIT   = 9;
    localparam int UNIT_W  = 4;
    localparam int VEC_W   = 4;
    localparam int NPIN_UNITS = 2;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             wr_one;
        logic             wr_zero;
        logic             chk_one;
        logic             exp_one;
        logic             chk_zero;
        logic             exp_zero;
    } vec_t;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic [VEC_W-1:0]  vec;
        logic [1:0]        sense;
    } fail_t;

    // Cells 0..3 share upper line 4 and walk the lower group downward;
    // cells 4..6 share lower line 3 and walk the upper group upward.
    function automatic logic [SEL_W-1:0] cell_addr(input logic [2:0] idx);
        if (idx < 3'd4)
            return {4'b0001, 4'b1000 >> idx};
        else
            return {4'b0001 << (idx - 3'd3), 4'b1000};
    endfunction

    function automatic logic [VEC_W-1:0] unit_last(input logic [UNIT_W-1:0] unit);
        return (unit < UNIT_W'(NPIN_UNITS)) ? VEC_W'(5) : VEC_W'(15);
    endfunction

    function automatic vec_t vec_decode(input logic [UNIT_W-1:0] unit,
                                        input logic [VEC_W-1:0]  vec);
        vec_t       v;
        logic [2:0] tgt;
        logic [2:0] k;
        v = '0;
        if (unit < UNIT_W'(NPIN_UNITS)) begin
            case (vec)
                4'd0: begin v.sel = cell_addr(3'd0); v.wr_one  = 1'b1; end
                4'd3: begin v.sel = cell_addr(3'd0); v.wr_zero = 1'b1; end
                4'd2, 4'd5: begin
                    v.sel      = cell_addr(3'd0);
                    v.chk_zero = ~unit[0];
                    v.chk_one  = unit[0];
                    v.exp_zero = (vec == 4'd2);
                    v.exp_one  = (vec == 4'd5);
                end
                default: v = '0;
            endcase
        end else begin
            tgt = 3'(unit - UNIT_W'(NPIN_UNITS));
            if (vec < 4'd7) begin
                v.sel    = cell_addr(vec[2:0]);
                v.wr_one = 1'b1;
            end else if (vec == 4'd7) begin
                v.sel     = cell_addr(tgt);
                v.wr_zero = 1'b1;
            end else if (vec == 4'd8) begin
                v = '0;
            end else if (vec < 4'd15) begin
                k          = 3'(vec - 4'd9);
                v.sel      = cell_addr((k < tgt) ? k : k + 3'd1);
                v.chk_zero = 1'b1;
                v.chk_one  = 1'b1;
                v.exp_zero = 1'b1;
                v.exp_one  = 1'b0;
            end else begin
                v.sel      = cell_addr(tgt);
                v.chk_zero = 1'b1;
                v.chk_one  = 1'b1;
                v.exp_zero = 1'b0;
                v.exp_one  = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/ram_pst_timer.sv
module ram_pst_timer #(
    parameter int PERIOD    = 20,
    parameter int STROBE_AT = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic at_strobe_o,
    output logic at_end_o
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] STROBE_C = CNT_W'(STROBE_AT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            cnt_q <= '0;
        else if (cnt_q == LAST_C)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_strobe_o = run_i && (cnt_q == STROBE_C);
    assign at_end_o    = run_i && (cnt_q == LAST_C);

    AST_STROBE_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
        at_end_o && !$past(at_end_o) |-> $past(at_strobe_o, PERIOD - 1 - STROBE_AT) || (STROBE_AT == PERIOD - 1)) else $error("strobe cycle misplaced"); // R7
endmodule

// File: rtl/ram_pst_vecgen.sv
module ram_pst_vecgen
    import ram_pst_pkg::*;
(
    input  logic              en_i,
    input  logic [UNIT_W-1:0] unit_i,
    input  logic [VEC_W-1:0]  vec_i,
    output vec_t              vec_o
);
    vec_t raw;

    always_comb begin
        raw   = vec_decode(unit_i, vec_i);
        vec_o = en_i ? raw : '0;
    end
endmodule

// File: rtl/ram_pst_cmp.sv
module ram_pst_cmp
    import ram_pst_pkg::*;
(
    input  vec_t vec_i,
    input  logic sense_one_n_i,
    input  logic sense_zero_n_i,
    output logic mism_o
);
    always_comb begin
        mism_o = (vec_i.chk_zero && (sense_zero_n_i != vec_i.exp_zero)) ||
                 (vec_i.chk_one  && (sense_one_n_i  != vec_i.exp_one));
    end
endmodule

// File: rtl/ram_pin_test_seq.sv
module ram_pin_test_seq
    import ram_pst_pkg::*;
#(
    parameter int PERIOD    = 20,
    parameter int STROBE_AT = 18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic [7:0]  sel_o,
    output logic        wr_one_o,
    output logic        wr_zero_o,
    input  logic        sense_one_n_i,
    input  logic        sense_zero_n_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        pass_o,
    output logic [3:0]  fail_unit_o,
    output logic [3:0]  fail_vec_o,
    output logic [1:0]  fail_sense_o
);
    localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(NUNIT - 1);

    run_state_e        st_q;
    logic [UNIT_W-1:0] unit_q;
    logic [VEC_W-1:0]  vec_q;
    logic              done_q, pass_q;
    fail_t             fail_q;
    logic              at_strobe, at_end, mism, busy;
    vec_t              cur;

    assign busy = (st_q == ST_RUN);

    ram_pst_timer #(.PERIOD(PERIOD), .STROBE_AT(STROBE_AT)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run_i      (busy),
        .at_strobe_o(at_strobe),
        .at_end_o   (at_end)
    );

    ram_pst_vecgen u_vecgen (
        .en_i  (busy),
        .unit_i(unit_q),
        .vec_i (vec_q),
        .vec_o (cur)
    );

    ram_pst_cmp u_cmp (
        .vec_i         (cur),
        .sense_one_n_i (sense_one_n_i),
        .sense_zero_n_i(sense_zero_n_i),
        .mism_o        (mism)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            unit_q <= '0;
            vec_q  <= '0;
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q   <= ST_RUN;
                        unit_q <= '0;
                        vec_q  <= '0;
                        pass_q <= 1'b0;
                        fail_q <= '0;
                    end
                end
                default: begin
                    if (at_strobe && mism) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                        pass_q <= 1'b0;
                        fail_q <= '{unit: unit_q, vec: vec_q,
                                    sense: {sense_one_n_i, sense_zero_n_i}};
                    end else if (at_end) begin
                        if (vec_q == unit_last(unit_q)) begin
                            vec_q <= '0;
                            if (unit_q == LAST_UNIT) begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                                pass_q <= 1'b1;
                            end else begin
                                unit_q <= unit_q + 1'b1;
                            end
                        end else begin
                            vec_q <= vec_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign sel_o        = cur.sel;
    assign wr_one_o     = cur.wr_one;
    assign wr_zero_o    = cur.wr_zero;
    assign busy_o       = busy;
    assign done_o       = done_q;
    assign pass_o       = pass_q;
    assign fail_unit_o  = fail_q.unit;
    assign fail_vec_o   = fail_q.vec;
    assign fail_sense_o = fail_q.sense;

    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (rst)
        ($countones(sel_o) == 0) || ($countones(sel_o) == 2)) else $error("select shape"); // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(wr_one_o && wr_zero_o)) else $error("both strobes"); // R6
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel_o == '0) |-> (!wr_one_o && !wr_zero_o)) else $error("strobe on deselect"); // R6
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_o && !at_end && !at_strobe |=> $stable(sel_o) && $stable(wr_one_o) && $stable(wr_zero_o)) else $error("vector moved"); // R7
    AST_FAIL_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
        done_o && !pass_o |-> $past(at_strobe)) else $error("fail off strobe"); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (sel_o == '0) && !wr_one_o && !wr_zero_o) else $error("idle drive"); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("done wide"); // R9
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && $past(busy_o)) else $error("done vs busy"); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy_o && !start_i |=> $stable(pass_o) && $stable(fail_unit_o) && $stable(fail_vec_o) && $stable(fail_sense_o)) else $error("result moved"); // R9
endmodule

// File: tb/ram_pin_test_seq_tb_top.sv
module ram_pin_test_seq_tb_top;
    localparam int P  = 20;
    localparam int S  = 18;
    localparam int NV = 124;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] sel;
    logic wr1, wr0, one_n, zero_n, busy, done, pass;
    logic [3:0] f_unit, f_vec;
    logic [1:0] f_sense;

    always #2 clk = ~clk;

    ram_pin_test_seq #(.PERIOD(P), .STROBE_AT(S)) dut_i (
        .clk(clk), .rst(rst), .start_i(start),
        .sel_o(sel), .wr_one_o(wr1), .wr_zero_o(wr0),
        .sense_one_n_i(one_n), .sense_zero_n_i(zero_n),
        .busy_o(busy), .done_o(done), .pass_o(pass),
        .fail_unit_o(f_unit), .fail_vec_o(f_vec), .fail_sense_o(f_sense)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // fault kinds: 0 none, 1 zero-sense stuck, 2 one-sense stuck, 3 dead store-0,
    // 4 dead store-1, 5 line stuck low, 6 line stuck high, 7 cell uncleareable, 8 glitch
    int   fk = 0;
    int   fa = 0;
    logic [15:0] mem;
    logic mem_clr = 1'b0;
    int   cyc_k = 0;
    int   run_k = 0;
    logic [7:0] cell_tab [7] = '{8'h18, 8'h14, 8'h12, 8'h11, 8'h28, 8'h48, 8'h88};

    function automatic logic [7:0] eff_sel(input logic [7:0] s);
        logic [7:0] e;
        e = s;
        if (fk == 5) e[fa] = 1'b0;
        if (fk == 6) e[fa] = 1'b1;
        return e;
    endfunction

    function automatic bit sel_ok(input logic [7:0] e);
        return ($countones(e[7:4]) == 1) && ($countones(e[3:0]) == 1);
    endfunction

    function automatic int sel_idx(input logic [7:0] e);
        int r = 0;
        int c = 0;
        for (int i = 0; i < 4; i++) begin
            if (e[4+i]) r = i;
            if (e[i]) c = i;
        end
        return r * 4 + c;
    endfunction

    always @(posedge clk) begin
        if (mem_clr) mem <= '0;
        else if (sel_ok(eff_sel(sel))) begin
            if (wr1 && fk != 4) mem[sel_idx(eff_sel(sel))] <= 1'b1;
            if (wr0 && fk != 3 && !(fk == 7 && sel == cell_tab[fa-1]))
                mem[sel_idx(eff_sel(sel))] <= 1'b0;
        end
    end

    always_comb begin
        logic [7:0] e;
        logic b;
        e = eff_sel(sel);
        b = mem[sel_idx(e)];
        zero_n = sel_ok(e) ? b : 1'b1;
        one_n  = sel_ok(e) ? ~b : 1'b1;
        if (fk == 1) zero_n = fa[0];
        if (fk == 2) one_n  = fa[0];
        if (fk == 8 && (cyc_k % P) != S) begin
            zero_n = ~zero_n;
            one_n  = ~one_n;
        end
    end

    // expected programme, written from R1..R4
    function automatic void exp_vec(input int g, output logic [7:0] s,
                                    output logic w1, output logic w0, output int cat);
        int u, v, t, i;
        s = 8'h00; w1 = 1'b0; w0 = 1'b0;
        if (g < 12) begin
            cat = 0; v = g % 6;
            if (v == 0) begin s = cell_tab[0]; w1 = 1'b1; end
            if (v == 3) begin s = cell_tab[0]; w0 = 1'b1; end
            if (v == 2 || v == 5) s = cell_tab[0];
        end else begin
            u = (g - 12) / 16; v = (g - 12) % 16; t = u;
            cat = (v < 9) ? 1 : 2;
            if (v < 7) begin s = cell_tab[v]; w1 = 1'b1; end
            else if (v == 7) begin s = cell_tab[t]; w0 = 1'b1; end
            else if (v < 15) begin i = v - 9; if (i >= t) i++; s = cell_tab[i]; end
            else if (v == 15) s = cell_tab[t];
        end
    endfunction

    bit   mon_en = 1'b0;
    int   mism_min = 0, mism_iso_w = 0, mism_iso_r = 0, mism_strb = 0;
    logic [7:0] seen_hi = '0, seen_lo = '0;

    always @(negedge clk) begin
        logic [7:0] es;
        logic ew1, ew0;
        int cat;
        if (busy) begin
            cyc_k = run_k;
            run_k++;
            if (mon_en) begin
                exp_vec(cyc_k / P, es, ew1, ew0, cat);
                if (sel != es || wr1 != ew1 || wr0 != ew0) begin
                    if (cat == 0) mism_min++;
                    else if (cat == 1) mism_iso_w++;
                    else mism_iso_r++;
                end
                if (!ew1 && !ew0 && (wr1 || wr0)) mism_strb++;
                if (cat == 2) begin seen_hi |= sel; seen_lo |= ~sel; end
            end
        end else run_k = 0;
    end

    function automatic int gidx(input int u, input int v);
        return (u < 2) ? u * 6 + v : 12 + (u - 2) * 16 + v;
    endfunction

    // expected {pass, unit, vec, sense}
    function automatic logic [10:0] exp_res(input int k, input int a);
        int cl;
        case (k)
            1: return (a == 0) ? {1'b0, 4'd0, 4'd2, 2'b00} : {1'b0, 4'd0, 4'd5, 2'b11};
            2: return (a == 1) ? {1'b0, 4'd1, 4'd2, 2'b11} : {1'b0, 4'd1, 4'd5, 2'b00};
            3: return {1'b0, 4'd0, 4'd5, 2'b01};
            4: return {1'b0, 4'd0, 4'd2, 2'b10};
            5: begin
                if (a == 3 || a == 4) return {1'b0, 4'd0, 4'd5, 2'b11};
                case (a) 2: cl = 2; 1: cl = 3; 0: cl = 4; 5: cl = 5; 6: cl = 6; default: cl = 7; endcase
                return {1'b0, 4'd2, 4'(cl + 7), 2'b11};
            end
            6: begin
                if (a == 4) return {1'b0, 4'd2, 4'd12, 2'b11};
                if (a == 3) return {1'b0, 4'd2, 4'd9, 2'b11};
                return {1'b0, 4'd0, 4'd5, 2'b11};
            end
            7: return (a == 1) ? {1'b0, 4'd0, 4'd5, 2'b01} : {1'b0, 4'(a + 1), 4'd15, 2'b01};
            default: return {1'b1, 4'd0, 4'd0, 2'b00};
        endcase
    endfunction

    task automatic run_case(input int k, input int a, input string req, input bit mid);
        logic [10:0] ex, got;
        int n, want;
        fk = k; fa = a;
        @(negedge clk); mem_clr = 1'b1;
        @(negedge clk); mem_clr = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1;
        while (!done && n < 6000) begin
            @(negedge clk);
            n++;
            start = (mid && n == 100);
        end
        start = 1'b0;
        if (!done) begin
            check(1'b0, req, "watchdog expired", n, 0);
            rst = 1'b1; @(negedge clk); rst = 1'b0;
            return;
        end
        ex  = exp_res(k, a);
        got = {pass, f_unit, f_vec, f_sense};
        check(got == ex, req, $sformatf("result {pass,unit,vec,sense} kind %0d arg %0d", k, a),
              int'(got), int'(ex));
        want = ex[10] ? NV * P + 1 : gidx(int'(ex[9:6]), int'(ex[5:2])) * P + S + 2;
        check(n == want, ex[10] ? "R9" : "R8", "cycles from start to done", n, want);
        @(negedge clk);
        check(!done, "R9", "done is one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        check({pass, f_unit, f_vec, f_sense} == ex, "R9", "result held while idle",
              int'({pass, f_unit, f_vec, f_sense}), int'(ex));
    endtask

    initial begin
        int k, a;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !pass && sel == 0 && !wr1 && !wr0 && f_unit == 0 && f_vec == 0 && f_sense == 0,
              "R10", "reset state", int'({busy, done, pass, sel}), 0);

        // golden run with a start pulse while busy (R9)
        mon_en = 1'b1;
        run_case(0, 0, "R9", 1'b1);
        mon_en = 1'b0;
        check(mism_min == 0, "R4", "minimum-pin vector mismatches", mism_min, 0);
        check(mism_iso_w == 0, "R2", "isolation write/deselect mismatches", mism_iso_w, 0);
        check(mism_iso_r == 0, "R3", "isolation read order mismatches", mism_iso_r, 0);
        check(mism_strb == 0, "R6", "strobe during read or deselect", mism_strb, 0);
        check(seen_hi == 8'hFF && seen_lo == 8'hFF, "R1", "every select line high and low",
              int'({seen_hi, seen_lo}), 16'hFFFF);

        // directed corners
        run_case(8, 0, "R7", 1'b0);   // sense wrong everywhere but the strobe cycle
        run_case(1, 0, "R5", 1'b0);
        run_case(1, 1, "R5", 1'b0);
        run_case(2, 0, "R5", 1'b0);
        run_case(2, 1, "R5", 1'b0);
        run_case(7, 7, "R3", 1'b0);   // last target detects an unclearable cell 7
        run_case(6, 3, "R8", 1'b0);

        for (int it = 0; it < 18; it++) begin
            k = $urandom_range(0, 8);
            case (k)
                1, 2: a = $urandom_range(0, 1);
                5, 6: a = $urandom_range(0, 7);
                7:    a = $urandom_range(1, 7);
                default: a = 0;
            endcase
            run_case(k, a, "R8", 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule